// File: doc/BRIEF.md
# Display Window Fetch Address Generator

This block turns line and frame strobes from a video timing generator into frame-buffer read requests for the visible display window. Each active line produces one request. The request carries the 32-bit word address where that line starts and the number of words to fetch. A downstream memory arbiter accepts each request through a valid/ready handshake.

Software programs two field base addresses and one packed window-size word. The size word holds the line width in words minus one, the number of lines per field minus one, and the line modulo. The block captures the size word at every frame strobe, so the window shape stays fixed for the whole field. In interlaced scan the odd field starts one line below the even field, and the modulo steps over the other field's lines. This lets the block walk a panned virtual frame buffer as two interleaved fields. In progressive scan the modulo is normally 1, and every line follows the one before it.

Top module: `dwf_fetch_agen`

## Requirements
- R1: After reset `req_valid` is 0. `line_start` strobes are ignored until the first `frame_start` has been seen.
- R2: On a `frame_start` with `cfg_interlace`=1 and `field_odd`=0, the first line's `req_addr` equals `cfg_long_base`.
- R3: On a `frame_start` with `cfg_interlace`=1 and `field_odd`=1, the first line's `req_addr` equals `cfg_short_base`.
- R4: With `cfg_interlace`=0 the first line's `req_addr` equals `cfg_long_base`, whatever the value of `field_odd`.
- R5: `cfg_win_size` is decoded as follows: bits 9:0 are the width in words minus one, bits 19:10 are the lines per field minus one, and bits 29:20 are the modulo. `req_words` equals bits 9:0 plus one.
- R6: Each accepted request advances the line address by width-in-words plus modulo minus one. The sum wraps modulo 2^ADDR_W.
- R7: Once lines-per-field requests have been issued in a field, further `line_start` strobes produce no request until the next `frame_start`.
- R8: While `req_valid`=1 and `req_ready`=0, `req_valid`, `req_addr` and `req_words` hold their values. A `frame_start` is the only exception.
- R9: A `line_start` that arrives while a request is outstanding is ignored. This includes a `line_start` in the cycle the request is accepted. An ignored strobe neither advances the address nor counts as a line.
- R10: The size word and the bases are sampled only at `frame_start`. Changes to them during a field do not affect that field's requests.
- R11: `frame_start` withdraws any outstanding request. `req_valid` is 0 in the following cycle, and the next line restarts at the newly selected base.
- R12: When `frame_start` and `line_start` arrive in the same cycle, `frame_start` takes effect, no request is raised, and the next `line_start` fetches the first line of the field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_long_base | input | ADDR_W | Word address of the first line of the even (long) field |
| cfg_short_base | input | ADDR_W | Word address of the first line of the odd (short) field |
| cfg_win_size | input | 30 | Packed width-1 / lines-1 / modulo |
| cfg_interlace | input | 1 | 1 selects interlaced scan |
| frame_start | input | 1 | Field start strobe |
| field_odd | input | 1 | Field parity, sampled with frame_start |
| line_start | input | 1 | Active line start strobe |
| req_valid | output | 1 | Fetch request pending |
| req_ready | input | 1 | Request accepted when high with req_valid |
| req_addr | output | ADDR_W | Line start word address |
| req_words | output | 11 | Words to fetch for this line |

## Verification
Some behaviours are checked by assertions on every cycle:
- a stalled request holds steady;
- a frame strobe clears the request in the next cycle;
- the count of issued lines never exceeds the programmed line count;
- each accepted request moves the line address by exactly the configured step;
- nothing is requested before the first frame strobe.

Other behaviours depend on concrete values, and only the bench scenarios can show them:
- the choice of field base for each parity and scan mode;
- the address sequence across a field, including wrap-around;
- that settings are held for the whole field;
- that strobes during a pending request are dropped.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

  localparam int FLD_W  = 10;
  localparam int SIZE_W = 3 * FLD_W;
  localparam int CNT_W  = FLD_W + 1;

  typedef struct packed {
    logic [FLD_W-1:0] modulo;
    logic [FLD_W-1:0] lines_m1;
    logic [FLD_W-1:0] width_m1;
  } win_size_t;

  function automatic win_size_t decode_size(input logic [SIZE_W-1:0] raw);
    win_size_t s;
    s.width_m1 = raw[FLD_W-1:0];
    s.lines_m1 = raw[2*FLD_W-1:FLD_W];
    s.modulo   = raw[3*FLD_W-1:2*FLD_W];
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] words_per_line(input win_size_t s);
    return {1'b0, s.width_m1} + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] lines_per_field(input win_size_t s);
    return {1'b0, s.lines_m1} + CNT_W'(1);
  endfunction

  // width + modulo - 1 == width_m1 + modulo
  function automatic logic [CNT_W-1:0] line_step(input win_size_t s);
    return {1'b0, s.width_m1} + {1'b0, s.modulo};
  endfunction

endpackage

// File: rtl/dwf_cfg_shadow.sv
module dwf_cfg_shadow
  import dwf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] size_raw,
  output win_size_t         size_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) size_q <= '0;
    else if (load) size_q <= decode_size(size_raw);
  end

endmodule

// File: rtl/dwf_line_ctr.sv
module dwf_line_ctr
  import dwf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             issue,
  input  logic [CNT_W-1:0] lines_total,
  output logic [CNT_W-1:0] lines_issued,
  output logic             field_done
);

  always_ff @(posedge clk) begin
    if (!rst_n)      lines_issued <= '0;
    else if (clear)  lines_issued <= '0;
    else if (issue)  lines_issued <= lines_issued + CNT_W'(1);
  end

  assign field_done = (lines_issued >= lines_total);

endmodule

// File: rtl/dwf_addr_reg.sv
module dwf_addr_reg
  import dwf_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              interlace,
  input  logic              odd_field,
  input  logic [ADDR_W-1:0] long_base,
  input  logic [ADDR_W-1:0] short_base,
  input  logic              advance,
  input  logic [CNT_W-1:0]  step,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int PAD_W = ADDR_W - CNT_W;

  function automatic logic [ADDR_W-1:0] pick_base(
    input logic il, input logic odd,
    input logic [ADDR_W-1:0] lb, input logic [ADDR_W-1:0] sb);
    return (il && odd) ? sb : lb;
  endfunction

  logic [ADDR_W-1:0] step_ext;
  assign step_ext = {{PAD_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_addr <= '0;
    else if (load)    cur_addr <= pick_base(interlace, odd_field, long_base, short_base);
    else if (advance) cur_addr <= cur_addr + step_ext;
  end

  // R6
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (cur_addr == $past(cur_addr) + $past(step_ext)));

endmodule

// File: rtl/dwf_fetch_agen.sv
module dwf_fetch_agen
  import dwf_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_long_base,
  input  logic [ADDR_W-1:0] cfg_short_base,
  input  logic [SIZE_W-1:0] cfg_win_size,
  input  logic              cfg_interlace,
  input  logic              frame_start,
  input  logic              field_odd,
  input  logic              line_start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_words
);

  win_size_t         size_q;
  logic [CNT_W-1:0]  lines_issued;
  logic              field_done;
  logic [ADDR_W-1:0] cur_addr;
  logic              armed;

  // named events for assertions
  logic issue_ev;
  logic accept_ev;

  assign issue_ev  = line_start && armed && !req_valid && !field_done && !frame_start;
  assign accept_ev = req_valid && req_ready && !frame_start;

  dwf_cfg_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .size_raw (cfg_win_size),
    .size_q   (size_q)
  );

  dwf_line_ctr u_lines (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (frame_start),
    .issue        (issue_ev),
    .lines_total  (lines_per_field(size_q)),
    .lines_issued (lines_issued),
    .field_done   (field_done)
  );

  dwf_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (frame_start),
    .interlace  (cfg_interlace),
    .odd_field  (field_odd),
    .long_base  (cfg_long_base),
    .short_base (cfg_short_base),
    .advance    (accept_ev),
    .step       (line_step(size_q)),
    .cur_addr   (cur_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_words <= '0;
    end else if (frame_start) begin
      armed     <= 1'b1;
      req_valid <= 1'b0;
    end else begin
      if (accept_ev) req_valid <= 1'b0;
      if (issue_ev) begin
        req_valid <= 1'b1;
        req_addr  <= cur_addr;
        req_words <= words_per_line(size_q);
      end
    end
  end

  // R1
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !req_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_words)));

  // R11
  frame_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !req_valid);

  // R7
  line_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lines_issued <= lines_per_field(size_q));

endmodule

// File: tb/dwf_fetch_agen_bench.sv
`timescale 1ns/1ps
module dwf_fetch_agen_bench;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] lb = '0, sb = '0;
  logic [29:0]   wsz = '0;
  logic          il = 1'b0, fs = 1'b0, odd = 1'b0, ls = 1'b0, rdy = 1'b1;
  logic          rv;
  logic [AW-1:0] ra;
  logic [10:0]   rw;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dwf_fetch_agen #(.ADDR_W(AW)) u_dwf_fetch_agen (
    .clk(clk), .rst_n(rst_n), .cfg_long_base(lb), .cfg_short_base(sb),
    .cfg_win_size(wsz), .cfg_interlace(il), .frame_start(fs), .field_odd(odd),
    .line_start(ls), .req_valid(rv), .req_ready(rdy), .req_addr(ra), .req_words(rw)
  );

  typedef struct packed {
    logic [23:0] lbase;
    logic [23:0] sbase;
    logic [9:0]  w;
    logic [9:0]  h;
    logic [9:0]  m;
    logic        ilace;
    logic        oddf;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{24'h001000, 24'h001140, 10'd319, 10'd2, 10'd321, 1'b1, 1'b0},
    '{24'h001000, 24'h001140, 10'd319, 10'd2, 10'd321, 1'b1, 1'b1},
    '{24'h002000, 24'h003000, 10'd319, 10'd2, 10'd1,   1'b0, 1'b1},
    '{24'h000055, 24'h000077, 10'd0,   10'd0, 10'd1,   1'b0, 1'b0},
    '{24'hFFFFFE, 24'h000100, 10'd3,   10'd1, 10'd1,   1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frame_pulse(input logic parity);
    @(negedge clk); fs = 1'b1; odd = parity;
    @(negedge clk); fs = 1'b0;
  endtask

  task automatic line_pulse();
    @(negedge clk); ls = 1'b1;
    @(negedge clk); ls = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, rv}, 32'd0);
    rst_n = 1'b1;
    line_pulse();
    chk("R1 line before frame", {31'd0, rv}, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] base;
      lb = VECS[v].lbase; sb = VECS[v].sbase; il = VECS[v].ilace;
      wsz = {VECS[v].m, VECS[v].h, VECS[v].w};
      base = (VECS[v].ilace && VECS[v].oddf) ? VECS[v].sbase : VECS[v].lbase;
      frame_pulse(VECS[v].oddf);
      for (int k = 0; k <= int'(VECS[v].h); k++) begin
        logic [AW-1:0] ex;
        ex = base + AW'(k) * (AW'(VECS[v].w) + AW'(VECS[v].m));
        line_pulse();
        chk("R5 valid on line", {31'd0, rv}, 32'd1);
        chk(k == 0 ? "R2/R3/R4 first addr" : "R6 line addr", {8'd0, ra}, {8'd0, ex});
        chk("R5 words", {21'd0, rw}, 32'(VECS[v].w) + 32'd1);
        @(negedge clk);
      end
      line_pulse();
      chk("R7 no request past field", {31'd0, rv}, 32'd0);
    end

    // R8 / R9: stall and ignored strobe
    lb = 24'h000200; il = 1'b0; wsz = {10'd1, 10'd3, 10'd7};
    rdy = 1'b0;
    frame_pulse(1'b0);
    line_pulse();
    chk("R8 valid raised", {31'd0, rv}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 hold valid", {31'd0, rv}, 32'd1);
    chk("R8 hold addr", {8'd0, ra}, 32'h200);
    line_pulse();
    chk("R9 pending line ignored", {8'd0, ra}, 32'h200);
    rdy = 1'b1;
    @(negedge clk);
    chk("R8 released", {31'd0, rv}, 32'd0);
    line_pulse();
    chk("R9 no extra advance", {8'd0, ra}, 32'h208);
    @(negedge clk);

    // R10: mid-field config change ignored
    wsz = {10'd5, 10'd3, 10'd20}; lb = 24'h009000;
    line_pulse();
    chk("R10 old step kept", {8'd0, ra}, 32'h210);
    chk("R10 old width kept", {21'd0, rw}, 32'd8);
    @(negedge clk);

    // R11: frame start withdraws pending request
    rdy = 1'b0;
    frame_pulse(1'b0);
    line_pulse();
    chk("R11 pending before abort", {31'd0, rv}, 32'd1);
    frame_pulse(1'b0);
    chk("R11 flushed", {31'd0, rv}, 32'd0);
    rdy = 1'b1;
    line_pulse();
    chk("R11 restart at base", {8'd0, ra}, 32'h9000);
    @(negedge clk);

    // R12: simultaneous strobes
    lb = 24'h004400;
    @(negedge clk); fs = 1'b1; ls = 1'b1; odd = 1'b0;
    @(negedge clk); fs = 1'b0; ls = 1'b0;
    chk("R12 no request on shared cycle", {31'd0, rv}, 32'd0);
    line_pulse();
    chk("R12 first line fetched", {8'd0, ra}, 32'h4400);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule